// File: doc/BRIEF.md
# Saturating Up/Down Event Counter

This block is a single counter field of configurable width, driven by hardware event requests. Each cycle it may add an increment step, subtract a decrement step, or take a value loaded by software. Each step is either a constant set by a parameter or a run-time input. Parameters choose the counting direction (up only by default, down only, or both). For each direction they also choose whether the count wraps or stops at a limit, and whether that limit is a constant or a run-time input.

The count and four status flags come out of the block. The flags tell when the count has reached an upper or lower threshold and when it rests on a saturation limit. Two combinational pulses announce, in the same cycle as the request, that the coming update is going to wrap past the top or the bottom of the range. A surrounding register block connects the load port to its software write path and uses the flags and pulses as event sources.

Top module: `sat_event_counter`

## Requirements
- R1: While rst_n is low, count is 0.
- R2: With inc_req high, the count grows by the increment step. The step is the parameter UP_STEP, or inc_step zero-extended when UP_STEP_DYN is 1.
- R3: With dec_req high, the count shrinks by the decrement step, chosen the same way from DN_STEP/DN_STEP_DYN and dec_step. When both requests are high, the net change is the increment step minus the decrement step.
- R4: With upper saturation on, a result above the upper limit becomes the limit. The limit comes from UP_LIMIT (default all ones) or from up_lim_in. Nothing wraps and ovf_pulse stays 0.
- R5: With lower saturation on, a result below the lower limit becomes the limit. The limit comes from DN_LIMIT (default 0) or from dn_lim_in. Nothing wraps and unf_pulse stays 0.
- R6: The clamping applies to every update: loads, counting and idle cycles, including the first edge after reset. The order is: wrap in each direction that does not saturate, then the upper clamp, then the lower clamp, so the lower limit wins if the limits cross.
- R7: ld_en high loads ld_val on the next edge, subject only to R6. Count requests in the same cycle are discarded.
- R8: ovf_pulse is high, in the cycle of the request, when upper saturation is off, no load is present, and the net result exceeds 2^W-1. The next count is that result minus 2^W.
- R9: unf_pulse is high, in the cycle of the request, when lower saturation is off, no load is present, and the net result is below 0. The next count is that result plus 2^W.
- R10: up_thr_hit is high exactly while count >= UP_THR, so it rises in the cycle the count first reaches UP_THR.
- R11: dn_thr_hit is high exactly while count <= DN_THR.
- R12: up_sat is high while upper saturation is on and count equals the active upper limit. dn_sat is high while lower saturation is on and count equals the active lower limit.
- R13: A request for a direction whose enable parameter (UP_EN, DN_EN) is 0 has no effect on the count and raises no pulse. The defaults are UP_EN=1 and DN_EN=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_req | input | 1 | Increment request |
| inc_step | input | STEP_W | Run-time increment step |
| dec_req | input | 1 | Decrement request |
| dec_step | input | STEP_W | Run-time decrement step |
| up_lim_in | input | W | Run-time upper saturation limit |
| dn_lim_in | input | W | Run-time lower saturation limit |
| ld_en | input | 1 | Software load strobe |
| ld_val | input | W | Value to load |
| count | output | W | Current count |
| ovf_pulse | output | 1 | Upward wrap predicted this cycle |
| unf_pulse | output | 1 | Downward wrap predicted this cycle |
| up_thr_hit | output | 1 | Count at or above upper threshold |
| dn_thr_hit | output | 1 | Count at or below lower threshold |
| up_sat | output | 1 | Count sits on the upper limit |
| dn_sat | output | 1 | Count sits on the lower limit |

## Verification
Three copies of the counter run in the bench. The first is 8 bits wide, with run-time steps, a run-time upper limit and a constant lower limit of 2. The second is a 4-bit counter that wraps in both directions. The third keeps the default up-only setup. The first copy sees single increments, single decrements, both at once, loads against limits that move, and an upper limit lowered beneath the count. These patterns separate a clamp that works only on counting from one that applies on every update, and they show which clamp wins. The 4-bit copies step through both thresholds and past both ends of the range, telling wrap from saturation. Feeding identical requests to the up/down copy and the up-only copy shows that a disabled direction is ignored.

// File: rtl/sec_pkg.sv
package sec_pkg;
    typedef enum logic [1:0] {
        SAT_NONE  = 2'd0,
        SAT_FIXED = 2'd1,
        SAT_INPUT = 2'd2
    } sat_mode_e;
endpackage

// File: rtl/sec_step_sel.sv
module sec_step_sel #(
    parameter int          W        = 8,
    parameter int          STEP_W   = 4,
    parameter bit          EN       = 1'b1,
    parameter bit          DYN      = 1'b0,
    parameter int unsigned FIX_STEP = 1
) (
    input  logic              req,
    input  logic [STEP_W-1:0] step_in,
    output logic [W-1:0]      amt
);
    localparam logic [W-1:0] FIX_V = W'(FIX_STEP);

    generate
        if (!EN) begin : g_off
            wire unused_in = ^{req, step_in};
            assign amt = '0;
        end else if (DYN) begin : g_dyn
            assign amt = req ? W'(step_in) : '0;
        end else begin : g_fix
            wire unused_in = ^step_in;
            assign amt = req ? FIX_V : '0;
        end
    endgenerate
endmodule

// File: rtl/sec_limit_sel.sv
module sec_limit_sel #(
    parameter int                W     = 8,
    parameter sec_pkg::sat_mode_e MODE = sec_pkg::SAT_NONE,
    parameter logic [W-1:0]      FIXED = '0,
    parameter logic [W-1:0]      DFLT  = '0
) (
    input  logic [W-1:0] lim_in,
    output logic [W-1:0] lim
);
    generate
        if (MODE == sec_pkg::SAT_INPUT) begin : g_in
            assign lim = lim_in;
        end else if (MODE == sec_pkg::SAT_FIXED) begin : g_fix
            wire unused_in = ^lim_in;
            assign lim = FIXED;
        end else begin : g_none
            wire unused_in = ^lim_in;
            assign lim = DFLT;
        end
    endgenerate
endmodule

// File: rtl/sat_event_counter.sv
module sat_event_counter #(
    parameter int                 W           = 8,
    parameter int                 STEP_W      = 4,
    parameter bit                 UP_EN       = 1'b1,
    parameter bit                 DN_EN       = 1'b0,
    parameter bit                 UP_STEP_DYN = 1'b0,
    parameter bit                 DN_STEP_DYN = 1'b0,
    parameter int unsigned        UP_STEP     = 1,
    parameter int unsigned        DN_STEP     = 1,
    parameter sec_pkg::sat_mode_e UP_SAT      = sec_pkg::SAT_NONE,
    parameter sec_pkg::sat_mode_e DN_SAT      = sec_pkg::SAT_NONE,
    parameter logic [W-1:0]       UP_LIMIT    = '1,
    parameter logic [W-1:0]       DN_LIMIT    = '0,
    parameter logic [W-1:0]       UP_THR      = '1,
    parameter logic [W-1:0]       DN_THR      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_req,
    input  logic [STEP_W-1:0] inc_step,
    input  logic              dec_req,
    input  logic [STEP_W-1:0] dec_step,
    input  logic [W-1:0]      up_lim_in,
    input  logic [W-1:0]      dn_lim_in,
    input  logic              ld_en,
    input  logic [W-1:0]      ld_val,
    output logic [W-1:0]      count,
    output logic              ovf_pulse,
    output logic              unf_pulse,
    output logic              up_thr_hit,
    output logic              dn_thr_hit,
    output logic              up_sat,
    output logic              dn_sat
);
    import sec_pkg::*;

    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] MAX_S  = {2'b00, {W{1'b1}}};
    localparam logic signed [XW-1:0] WRAP_S = {2'b01, {W{1'b0}}};
    localparam bit UP_CLAMP = (UP_SAT != SAT_NONE);
    localparam bit DN_CLAMP = (DN_SAT != SAT_NONE);

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0]           up_amt, dn_amt;
    logic [W-1:0]           up_lim, dn_lim;
    logic signed [XW-1:0]   net_s, cand_s;
    logic signed [XW-1:0]   up_lim_s, dn_lim_s;

    sec_step_sel #(
        .W(W), .STEP_W(STEP_W), .EN(UP_EN), .DYN(UP_STEP_DYN), .FIX_STEP(UP_STEP)
    ) u_up_step (
        .req(inc_req), .step_in(inc_step), .amt(up_amt)
    );

    sec_step_sel #(
        .W(W), .STEP_W(STEP_W), .EN(DN_EN), .DYN(DN_STEP_DYN), .FIX_STEP(DN_STEP)
    ) u_dn_step (
        .req(dec_req), .step_in(dec_step), .amt(dn_amt)
    );

    sec_limit_sel #(
        .W(W), .MODE(UP_SAT), .FIXED(UP_LIMIT), .DFLT({W{1'b1}})
    ) u_up_lim (
        .lim_in(up_lim_in), .lim(up_lim)
    );

    sec_limit_sel #(
        .W(W), .MODE(DN_SAT), .FIXED(DN_LIMIT), .DFLT({W{1'b0}})
    ) u_dn_lim (
        .lim_in(dn_lim_in), .lim(dn_lim)
    );

    assign up_lim_s = $signed({2'b00, up_lim});
    assign dn_lim_s = $signed({2'b00, dn_lim});

    always_comb begin
        state_d = state_q;
        net_s   = $signed({2'b00, state_q.cnt}) + $signed({2'b00, up_amt})
                - $signed({2'b00, dn_amt});
        cand_s  = ld_en ? $signed({2'b00, ld_val}) : net_s;
        // wrap only in directions that do not saturate
        if (!UP_CLAMP && (cand_s > MAX_S)) begin
            cand_s = cand_s - WRAP_S;
        end
        if (!DN_CLAMP && cand_s[XW-1]) begin
            cand_s = cand_s + WRAP_S;
        end
        // upper clamp first, lower clamp last (lower wins on crossed limits)
        if (UP_CLAMP && (cand_s > up_lim_s)) begin
            cand_s = up_lim_s;
        end
        if (DN_CLAMP && (cand_s < dn_lim_s)) begin
            cand_s = dn_lim_s;
        end
        state_d.cnt = cand_s[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count      = state_q.cnt;
    assign ovf_pulse  = !UP_CLAMP && !ld_en && (net_s > MAX_S);
    assign unf_pulse  = !DN_CLAMP && !ld_en && net_s[XW-1];
    assign up_thr_hit = (state_q.cnt >= UP_THR);
    assign dn_thr_hit = (state_q.cnt <= DN_THR);
    assign up_sat     = UP_CLAMP && (state_q.cnt == up_lim);
    assign dn_sat     = DN_CLAMP && (state_q.cnt == dn_lim);

    // R8: an announced upward wrap lands below the previous count
    a_r8_ovf_wraps_down: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> (count < $past(count)));

    // R9: an announced downward wrap lands above the previous count
    a_r9_unf_wraps_up: assert property (@(posedge clk) disable iff (!rst_n)
        unf_pulse |=> (count > $past(count)));

    // R4: with consistent limits the count never passes the upper limit
    a_r4_upper_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (UP_CLAMP && (dn_lim <= up_lim)) |=> (count <= $past(up_lim)));

    // R5: the count never drops below the lower limit
    a_r5_lower_bound: assert property (@(posedge clk) disable iff (!rst_n)
        DN_CLAMP |=> (count >= $past(dn_lim)));

    // R7: an in-range load is taken verbatim
    a_r7_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && (ld_val <= up_lim) && (ld_val >= dn_lim)) |=> (count == $past(ld_val)));
endmodule

// File: tb/sim_sat_event_counter.sv
`timescale 1ns/1ps
module sim_sat_event_counter;
    import sec_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // u0: 8-bit, run-time steps, run-time upper limit, fixed lower limit 2
    logic       a_inc = 0, a_dec = 0, a_ld = 0;
    logic [3:0] a_is = 0, a_ds = 0;
    logic [7:0] a_ul = 8'd200, a_lv = 0;
    logic [7:0] a_cnt;
    logic       a_ovf, a_unf, a_ut, a_dt, a_us, a_dsat;

    // u1 (4-bit up/down wrapping) and u2 (defaults) share these inputs
    logic       b_inc = 0, b_dec = 0, b_ld = 0;
    logic [3:0] b_lv = 0;
    logic [3:0] b1_cnt, b2_cnt;
    logic       b1_ovf, b1_unf, b1_ut, b1_dt, b1_us, b1_ds;
    logic       b2_ovf, b2_unf, b2_ut, b2_dt, b2_us, b2_ds;

    sat_event_counter #(
        .W(8), .STEP_W(4), .UP_EN(1'b1), .DN_EN(1'b1),
        .UP_STEP_DYN(1'b1), .DN_STEP_DYN(1'b1),
        .UP_SAT(SAT_INPUT), .DN_SAT(SAT_FIXED), .DN_LIMIT(8'd2),
        .UP_THR(8'd100), .DN_THR(8'd10)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .inc_req(a_inc), .inc_step(a_is),
        .dec_req(a_dec), .dec_step(a_ds), .up_lim_in(a_ul), .dn_lim_in(8'd0),
        .ld_en(a_ld), .ld_val(a_lv), .count(a_cnt), .ovf_pulse(a_ovf),
        .unf_pulse(a_unf), .up_thr_hit(a_ut), .dn_thr_hit(a_dt),
        .up_sat(a_us), .dn_sat(a_dsat)
    );

    sat_event_counter #(
        .W(4), .STEP_W(2), .UP_EN(1'b1), .DN_EN(1'b1),
        .UP_THR(4'd6), .DN_THR(4'd7)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .inc_req(b_inc), .inc_step(2'd0),
        .dec_req(b_dec), .dec_step(2'd0), .up_lim_in(4'd0), .dn_lim_in(4'd0),
        .ld_en(b_ld), .ld_val(b_lv), .count(b1_cnt), .ovf_pulse(b1_ovf),
        .unf_pulse(b1_unf), .up_thr_hit(b1_ut), .dn_thr_hit(b1_dt),
        .up_sat(b1_us), .dn_sat(b1_ds)
    );

    sat_event_counter #(
        .W(4), .STEP_W(2)
    ) u2 (
        .clk(clk), .rst_n(rst_n), .inc_req(b_inc), .inc_step(2'd0),
        .dec_req(b_dec), .dec_step(2'd0), .up_lim_in(4'd0), .dn_lim_in(4'd0),
        .ld_en(b_ld), .ld_val(b_lv), .count(b2_cnt), .ovf_pulse(b2_ovf),
        .unf_pulse(b2_unf), .up_thr_hit(b2_ut), .dn_thr_hit(b2_dt),
        .up_sat(b2_us), .dn_sat(b2_ds)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // scoreboard: {cnt[7:0], ovf, unf, up_thr, dn_thr, up_sat, dn_sat}
    int          q_inst[$];
    logic [13:0] q_exp[$];
    string       q_req[$];

    task automatic push(input int inst, input logic [13:0] e, input string r);
        q_inst.push_back(inst);
        q_exp.push_back(e);
        q_req.push_back(r);
    endtask

    task automatic a_cyc(input bit inc, input bit dec, input logic [3:0] is,
                         input logic [3:0] ds, input logic [7:0] ul,
                         input bit ld, input logic [7:0] lv,
                         input logic [7:0] ecnt, input bit eo, input bit eu,
                         input bit et, input bit ed, input bit es, input bit ez,
                         input string r);
        @(negedge clk);
        a_inc = inc; a_dec = dec; a_is = is; a_ds = ds;
        a_ul = ul; a_ld = ld; a_lv = lv;
        push(0, {ecnt, eo, eu, et, ed, es, ez}, r);
    endtask

    task automatic b_cyc(input bit inc, input bit dec, input bit ld,
                         input logic [3:0] lv,
                         input logic [3:0] c1, input bit o1, input bit u1f,
                         input bit t1, input bit d1,
                         input logic [3:0] c2, input bit o2,
                         input bit t2, input bit d2, input string r);
        @(negedge clk);
        b_inc = inc; b_dec = dec; b_ld = ld; b_lv = lv;
        push(1, {4'd0, c1, o1, u1f, t1, d1, 2'b00}, r);
        push(2, {4'd0, c2, o2, 1'b0, t2, d2, 2'b00}, r);
    endtask

    task automatic chk_now(input logic [7:0] act, input logic [7:0] exp, input string r);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    // monitor: pulses sampled before the edge, count and flags after it
    logic p_ao, p_au, p_1o, p_1u, p_2o, p_2u;
    initial begin
        forever begin
            @(negedge clk);
            #2;
            p_ao = a_ovf; p_au = a_unf;
            p_1o = b1_ovf; p_1u = b1_unf;
            p_2o = b2_ovf; p_2u = b2_unf;
            @(posedge clk);
            #2;
            while (q_inst.size() > 0) begin
                int          inst;
                logic [13:0] e;
                logic [13:0] act;
                string       r;
                inst = q_inst.pop_front();
                e    = q_exp.pop_front();
                r    = q_req.pop_front();
                if (inst == 0)
                    act = {a_cnt, p_ao, p_au, a_ut, a_dt, a_us, a_dsat};
                else if (inst == 1)
                    act = {4'd0, b1_cnt, p_1o, p_1u, b1_ut, b1_dt, b1_us, b1_ds};
                else
                    act = {4'd0, b2_cnt, p_2o, p_2u, b2_ut, b2_dt, b2_us, b2_ds};
                checks++;
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: u%0d actual %h expected %h", r, inst, act, e);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: count held at zero during reset
        chk_now(a_cnt, 8'd0, "R1 u0 reset");
        chk_now({4'd0, b1_cnt}, 8'd0, "R1 u1 reset");
        chk_now({4'd0, b2_cnt}, 8'd0, "R1 u2 reset");
        rst_n = 1'b1;

        // u0: saturating, run-time steps and upper limit
        a_cyc(0,0,0,0,200,0,0,  8'd2,  0,0,0,1,0,1, "R6 idle clamp to lower limit");
        a_cyc(1,0,5,0,200,0,0,  8'd7,  0,0,0,1,0,0, "R2 inc step 5");
        a_cyc(1,0,15,0,200,0,0, 8'd22, 0,0,0,0,0,0, "R2 inc step 15");
        a_cyc(1,1,4,9,200,0,0,  8'd17, 0,0,0,0,0,0, "R3 net inc4 dec9");
        a_cyc(0,1,0,15,200,0,0, 8'd2,  0,0,0,1,0,1, "R3 dec step 15");
        a_cyc(0,1,0,3,200,0,0,  8'd2,  0,0,0,1,0,1, "R5 lower saturation");
        a_cyc(1,0,5,0,200,1,150,8'd150,0,0,1,0,0,0, "R7 load beats inc");
        a_cyc(1,0,15,0,200,0,0, 8'd165,0,0,1,0,0,0, "R10 inc above threshold");
        a_cyc(1,0,15,0,170,0,0, 8'd170,0,0,1,0,1,0, "R4 clamp to run-time limit");
        a_cyc(1,0,15,0,170,0,0, 8'd170,0,0,1,0,1,0, "R4 stays at limit no ovf");
        a_cyc(0,0,0,0,120,0,0,  8'd120,0,0,1,0,1,0, "R6 lowered limit idle");
        a_cyc(0,0,0,0,120,1,250,8'd120,0,0,1,0,1,0, "R6 load clamped high");
        a_cyc(0,0,0,0,120,1,0,  8'd2,  0,0,0,1,0,1, "R6 load clamped low");
        a_cyc(0,0,0,0,255,1,250,8'd250,0,0,1,0,0,0, "R7 load 250");
        a_cyc(1,0,15,0,255,0,0, 8'd255,0,0,1,0,1,0, "R4 all-ones limit no wrap");
        a_cyc(1,1,3,3,255,0,0,  8'd255,0,0,1,0,1,0, "R12 saturated indicator held");
        a_cyc(0,0,0,0,255,0,0,  8'd255,0,0,1,0,1,0, "R12 idle at limit");

        // u1 wrapping up/down, u2 default up-only
        b_cyc(0,0,1,4, 4'd4, 0,0,0,1, 4'd4, 0,0,0, "R7 load 4");
        b_cyc(1,0,0,0, 4'd5, 0,0,0,1, 4'd5, 0,0,0, "R2 fixed step");
        b_cyc(1,0,0,0, 4'd6, 0,0,1,1, 4'd6, 0,0,0, "R10 threshold 6 reached");
        b_cyc(1,0,0,0, 4'd7, 0,0,1,1, 4'd7, 0,0,0, "R11 at down threshold");
        b_cyc(1,0,0,0, 4'd8, 0,0,1,0, 4'd8, 0,0,0, "R11 above down threshold");
        b_cyc(0,0,1,14,4'd14,0,0,1,0, 4'd14,0,0,0, "R7 load 14");
        b_cyc(1,0,0,0, 4'd15,0,0,1,0, 4'd15,0,1,0, "R10 at max");
        b_cyc(1,0,0,0, 4'd0, 1,0,0,1, 4'd0, 1,0,1, "R8 overflow wrap");
        b_cyc(1,1,0,0, 4'd0, 0,0,0,1, 4'd1, 0,0,0, "R13 dec ignored with inc");
        b_cyc(0,1,0,0, 4'd15,0,1,1,0, 4'd1, 0,0,0, "R9 underflow wrap R13");
        b_cyc(0,1,0,0, 4'd14,0,0,1,0, 4'd1, 0,0,0, "R3 dec R13 ignored");
        b_cyc(0,0,0,0, 4'd14,0,0,1,0, 4'd1, 0,0,0, "R13 idle");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule